// File: doc/BRIEF.md
# Daisy-Chained Interrupt Vector Responder

This block sits on a peripheral board and turns a set of local interrupt sources into one active-low request line on a shared handshake bus. Each source raises a one-cycle pulse. The block keeps it as a pending bit until the CPU services it. When the CPU acknowledges, the block checks a priority-in signal. This signal passes from board to board as a daisy chain. If the block holds priority and has work pending, it claims the cycle and drives an interrupt vector onto the data bus. The vector is a configurable base plus the index of the lowest-numbered pending source. If the block does not claim the cycle, it leaves the bus alone and, when that is allowed, passes priority to the next board.

The acknowledge, SYN and request lines are active low. The block samples them synchronously on its own clock. The moment that decides the claim is the clock where SYN is first seen asserted while the acknowledge is active. From then until SYN is released, new source pulses are parked and do not reach the pending set. The request line therefore cannot change during an acknowledge. The served source is retired on the clock that sees the acknowledge released. The vector stays on the bus for one more cycle after that clock.

Top module: `irq_vec_responder`

## Requirements
- R1: A pulse on `src_req[i]` sampled high at a clock (while SYN is not asserted) makes source i pending at that clock, and `irq_n` goes low one clock later.
- R2: A pending source stays pending, and `irq_n` stays low, until that source is served or reset is applied.
- R3: While `syn_n` is sampled low, source pulses do not enter the pending set and `irq_n` does not change. Such pulses are held and become pending at the first clock where `syn_n` is sampled high.
- R4: At the first clock where `syn_n` is sampled low while `ack_n` is low, the block claims the cycle if `prio_in` is high and at least one source is pending. It selects the lowest-numbered pending source.
- R5: After a claim, `data_oe` is high from the next clock until one clock after the clock that samples `ack_n` high, and `data` carries `vec_base` plus the selected index, modulo 2^VW.
- R6: Whenever `data_oe` is low, `data` is all zeros.
- R7: `prio_out` is a registered copy of `prio_in`. It is forced low while `ack_n` is low and a source is pending, and while the block holds a claim.
- R8: The selected source's pending bit clears at the clock that samples `ack_n` high. `irq_n` rises one clock later if no other source is pending.
- R9: If `prio_in` is low when SYN starts, the block does not claim, never drives `data_oe`, and keeps every pending bit.
- R10: While `rst` is high at a clock, all pending and held bits clear, `irq_n` goes high, and `data_oe`, `data` and `prio_out` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N | Per-source interrupt pulses |
| vec_base | input | VW | Base vector value |
| ack_n | input | 1 | Interrupt acknowledge from the CPU, active low |
| syn_n | input | 1 | Bus SYN strobe, active low |
| prio_in | input | 1 | Daisy-chain priority in, high = may respond |
| irq_n | output | 1 | Interrupt request, active low, registered |
| prio_out | output | 1 | Daisy-chain priority out to the next board |
| data | output | VW | Vector value for the data bus, zero when not driving |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check on every cycle that the vector is never driven while priority is being passed on and never without an active request. They also check that the data value is zero whenever the enable is low, that an inactive priority-in always gives an inactive priority-out, and that the request line holds steady while SYN and the acknowledge are both active. Only the bench scenarios can show which index is picked from a given pending pattern and that the base is added with wraparound. They also show that a pulse parked during SYN later turns into a real request, and that the exact source is retired so that the request line rises or stays low as the remaining pattern dictates.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
  // Registered copy of the bus strobes, used for edge detection
  typedef struct packed {
    logic ack;
    logic syn;
  } bus_pair_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_scan
    assign seen[i+1] = seen[i] | req[i];
    assign first[i]  = req[i] & ~seen[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/irq_collect.sv
module irq_collect #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  src_req,
  input  logic          freeze,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend
);
  logic [N-1:0] held;
  logic [N-1:0] clr_mask;

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign clr_mask[i] = clr_en && (clr_idx == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      held <= '0;
    end else if (freeze) begin
      held <= held | src_req;
      pend <= pend & ~clr_mask;
    end else begin
      held <= '0;
      pend <= (pend & ~clr_mask) | held | src_req;
    end
  end
endmodule

// File: rtl/irq_grant.sv
module irq_grant
  import irq_resp_pkg::*;
#(
  parameter int VW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_a,
  input  logic          syn_a,
  input  logic          prio_in,
  input  logic          pend_any,
  input  logic [IW-1:0] sel,
  input  logic [VW-1:0] vec_base,
  output logic          clr_en,
  output logic [IW-1:0] clr_idx,
  output logic [VW-1:0] data,
  output logic          data_oe,
  output logic          prio_out
);
  bus_pair_t     prev;
  logic          hold;
  logic [IW-1:0] sel_r;
  logic          syn_start;
  logic          ack_end;

  assign syn_start = syn_a & ~prev.syn;
  assign ack_end   = prev.ack & ~ack_a;
  assign clr_en    = ack_end & hold;
  assign clr_idx   = sel_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= '0;
      hold     <= 1'b0;
      sel_r    <= '0;
      data     <= '0;
      data_oe  <= 1'b0;
      prio_out <= 1'b0;
    end else begin
      prev.ack <= ack_a;
      prev.syn <= syn_a;
      if (ack_end) begin
        hold <= 1'b0;
      end else if (syn_start && ack_a && prio_in && pend_any) begin
        hold  <= 1'b1;
        sel_r <= sel;
      end
      data_oe  <= hold;
      data     <= hold ? (vec_base + VW'(sel_r)) : '0;
      prio_out <= prio_in && !hold && !(ack_a && pend_any);
    end
  end
endmodule

// File: rtl/irq_vec_responder.sv
module irq_vec_responder #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  src_req,
  input  logic [VW-1:0] vec_base,
  input  logic          ack_n,
  input  logic          syn_n,
  input  logic          prio_in,
  output logic          irq_n,
  output logic          prio_out,
  output logic [VW-1:0] data,
  output logic          data_oe
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  pend;
  logic [IW-1:0] sel;
  logic          pend_any;
  logic          clr_en;
  logic [IW-1:0] clr_idx;
  logic          ack_a;
  logic          syn_a;

  assign ack_a = ~ack_n;
  assign syn_a = ~syn_n;

  irq_collect #(.N(N), .IW(IW)) u_collect (
    .clk(clk), .rst(rst), .src_req(src_req), .freeze(syn_a),
    .clr_en(clr_en), .clr_idx(clr_idx), .pend(pend)
  );

  irq_pick #(.N(N), .IW(IW)) u_pick (
    .req(pend), .idx(sel), .any(pend_any)
  );

  irq_grant #(.VW(VW), .IW(IW)) u_grant (
    .clk(clk), .rst(rst), .ack_a(ack_a), .syn_a(syn_a), .prio_in(prio_in),
    .pend_any(pend_any), .sel(sel), .vec_base(vec_base),
    .clr_en(clr_en), .clr_idx(clr_idx), .data(data), .data_oe(data_oe),
    .prio_out(prio_out)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~pend_any;
  end
endmodule

// File: rtl/irq_vec_responder_chk.sv
module irq_vec_responder_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ack_n,
  input logic          syn_n,
  input logic          prio_in,
  input logic          irq_n,
  input logic          prio_out,
  input logic [VW-1:0] data,
  input logic          data_oe
);
  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (irq_n && !data_oe && !prio_out));

  // R7
  chain_off_chk: assert property (@(posedge clk) disable iff (rst)
    !prio_in |=> !prio_out);

  // R7
  drive_blocks_chain_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> !prio_out);

  // R4
  drive_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> !irq_n);

  // R6
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data == '0));

  // R3
  frozen_request_chk: assert property (@(posedge clk) disable iff (rst)
    (!syn_n && !ack_n) |-> ##2 $stable(irq_n));
endmodule

bind irq_vec_responder irq_vec_responder_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst(rst), .ack_n(ack_n), .syn_n(syn_n), .prio_in(prio_in),
  .irq_n(irq_n), .prio_out(prio_out), .data(data), .data_oe(data_oe)
);

// File: tb/irq_vec_responder_bench.sv
module irq_vec_responder_bench;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int ROWS = 6;
  // row: base[21:14] src[13:6] prio[5] exp_oe[4] exp_idx[3:1] exp_irq_after[0]
  localparam logic [21:0] TBL [ROWS] = '{
    {8'h40, 8'b0000_0001, 1'b1, 1'b1, 3'd0, 1'b1},
    {8'h40, 8'b1010_0000, 1'b1, 1'b1, 3'd5, 1'b0},
    {8'hFE, 8'b1000_0000, 1'b1, 1'b1, 3'd7, 1'b1},
    {8'h40, 8'b0000_0110, 1'b0, 1'b0, 3'd0, 1'b0},
    {8'h40, 8'b0000_0000, 1'b1, 1'b0, 3'd0, 1'b1},
    {8'hFC, 8'b1111_1111, 1'b1, 1'b1, 3'd0, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          ack_n = 1'b1;
  logic          syn_n = 1'b1;
  logic          prio_in = 1'b0;
  logic [N-1:0]  src_req = '0;
  logic [VW-1:0] vec_base = '0;
  logic          irq_n, prio_out, data_oe;
  logic [VW-1:0] data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irq_vec_responder #(.N(N), .VW(VW)) u_irq_vec_responder (
    .clk(clk), .rst(rst), .src_req(src_req), .vec_base(vec_base),
    .ack_n(ack_n), .syn_n(syn_n), .prio_in(prio_in), .irq_n(irq_n),
    .prio_out(prio_out), .data(data), .data_oe(data_oe)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ack_n = 1'b1; syn_n = 1'b1; prio_in = 1'b0; src_req = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, s;
    logic p, eo, eirq;
    logic [2:0] ei;

    // R10 reset state
    do_reset();
    chk("R10 irq_n", irq_n, 1);
    chk("R10 data_oe", data_oe, 0);
    chk("R10 prio_out", prio_out, 0);
    chk("R10 data", data, 0);

    for (int r = 0; r < ROWS; r++) begin
      {b, s, p, eo, ei, eirq} = TBL[r];
      do_reset();
      vec_base = b; prio_in = p; src_req = s;
      tick();
      src_req = '0;
      tick();
      chk("R1 irq_n", irq_n, (s != 0) ? 0 : 1);
      ack_n = 1'b0;
      tick();
      chk("R7 prio_out at ack", prio_out, (p && s == 0) ? 1 : 0);
      syn_n = 1'b0;
      tick(); tick();
      chk("R5 data_oe", data_oe, eo);
      chk("R4 vector", data, eo ? 32'(8'(b + 8'(ei))) : 0);
      chk("R7 prio_out in cycle", prio_out, (p && s == 0) ? 1 : 0);
      ack_n = 1'b1; syn_n = 1'b1;
      tick();
      chk("R5 data_oe after release", data_oe, eo);
      if (eo) chk("R8 irq_n still low", irq_n, 0);
      tick();
      chk("R6 data_oe off", data_oe, 0);
      chk("R6 data zero", data, 0);
      chk(p ? "R8 irq_n after serve" : "R9 pending kept", irq_n, eirq);
    end

    // R3: pulse during SYN is parked, then released
    do_reset();
    prio_in = 1'b1; vec_base = 8'h00;
    ack_n = 1'b0; tick();
    syn_n = 1'b0; tick();
    src_req = 8'b0000_1000; tick();
    src_req = '0; tick();
    chk("R3 irq_n held high", irq_n, 1);
    chk("R3 prio_out passes", prio_out, 1);
    tick();
    chk("R3 irq_n still high", irq_n, 1);
    ack_n = 1'b1; syn_n = 1'b1;
    tick(); tick();
    chk("R3 parked request appears", irq_n, 0);
    // R2 sticky
    tick(); tick(); tick(); tick();
    chk("R2 irq_n sticky", irq_n, 0);
    ack_n = 1'b0; tick();
    syn_n = 1'b0; tick(); tick();
    chk("R4 parked source served", data, 3);
    chk("R5 data_oe", data_oe, 1);
    ack_n = 1'b1; syn_n = 1'b1;
    tick(); tick();
    chk("R8 irq_n released", irq_n, 1);

    // R10 reset clears pending
    src_req = 8'b0100_0000; tick();
    src_req = '0; tick();
    chk("R1 irq_n low", irq_n, 0);
    rst = 1'b1; tick(); tick();
    rst = 1'b0; tick(); tick();
    chk("R10 pending cleared", irq_n, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule